// File: doc/BRIEF.md
# Interrupt Remapping Unit

This block sits between an untrusted device-message path and a trusted interrupt controller. A device's interrupt message carries nothing but an opaque message handle and the device's 16-bit bus/device/function requester value. The handle selects an entry in a remapping table that only the host writes. That entry alone supplies the vector, destination and delivery mode that reach the controller. The entry also names the one requester that may use it. Messages that point at an empty entry, or that come from the wrong requester, never become interrupts. Each one becomes a fault report that carries the handle and the requester.

A small direct-mapped cache of table entries serves repeated handles quickly. On a cache miss the unit stalls its message input, reads the table, fills the cache line and then delivers. Every accepted message therefore produces exactly one result, and results leave in the order the messages were accepted. A host write to a table entry removes any cached copy of that entry in the same cycle, so the next use sees the new contents.

Top module: `irq_remap_unit`

## Requirements
- R1: After reset no result is valid, `msg_ready` is high, and every table entry is absent. A message sent before any host write is reported as an absent-entry fault.
- R2: A message whose entry is present and whose requester equals the entry's requester produces `irq_valid` for one cycle. The vector, destination and mode are taken from the entry, never from the message. Mode codes are 0 fixed, 1 lowest-priority, 2 non-maskable, 3 external.
- R3: A message whose entry is absent raises `fault_valid` with `fault_kind` = 0 and the message's handle and requester. `irq_valid` stays low.
- R4: A message whose entry is present but whose requester differs raises `fault_valid` with `fault_kind` = 1 and the handle and requester. `irq_valid` stays low.
- R5: The cache is direct-mapped. The line is the low `LINE_W` bits of the handle and the tag is the remaining bits. On a hit the result is registered on the accepting clock edge and is valid in the following cycle.
- R6: On a miss, `msg_ready` drops in the next cycle. The result appears `MISS_LAT` clock edges after the accepting edge. The entry read from the table, present or not, then replaces whatever that line held.
- R7: A host write to an entry invalidates a cached copy of that entry in the same cycle. The next message using that handle misses and sees the new contents. A host write in the same cycle as the acceptance of a message with that handle also forces a miss.
- R8: Each accepted message yields exactly one result, in acceptance order, even when a hit follows a miss. A message held on `msg_valid` while `msg_ready` is low is not taken until `msg_ready` returns.
- R9: When an entry is absent and the requester also differs, the fault is reported as absent (`fault_kind` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Device message offered |
| msg_ready | output | 1 | Unit can accept a message this cycle |
| msg_id | input | ID_W | Opaque message handle (table index) |
| msg_rid | input | 16 | Requester bus/device/function of the sender |
| host_we | input | 1 | Host writes one table entry |
| host_idx | input | ID_W | Entry written by the host |
| host_present | input | 1 | New entry is valid |
| host_rid | input | 16 | Requester allowed to use the entry |
| host_vector | input | 8 | Interrupt vector of the entry |
| host_dest | input | 8 | Destination of the entry |
| host_mode | input | 2 | Delivery mode of the entry |
| irq_valid | output | 1 | Validated interrupt delivery |
| irq_vector | output | 8 | Delivered vector |
| irq_dest | output | 8 | Delivered destination |
| irq_mode | output | 2 | Delivered mode |
| fault_valid | output | 1 | Rejected message report |
| fault_kind | output | 1 | 0 absent entry, 1 requester mismatch |
| fault_msg_id | output | ID_W | Handle of the rejected message |
| fault_rid | output | 16 | Requester of the rejected message |

## Verification
The hardest situation to reach from the ports is a host write that lands in the same cycle as the acceptance of a message whose entry is already cached. In that case the stale line must neither hit nor be refilled with old data. The stimulus first warms the line with a miss and a hit. It then drives the host write and the message together on one edge and expects miss timing with the new vector. Line eviction is reached by alternating two handles that share a low-order line index. Ordering behind a miss is reached by offering the next message while `msg_ready` is still low.

// File: rtl/irq_remap_pkg.sv
package irq_remap_pkg;

    localparam int RID_W  = 16;
    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;

    typedef enum logic [1:0] {
        MODE_FIXED  = 2'd0,
        MODE_LOWEST = 2'd1,
        MODE_NMI    = 2'd2,
        MODE_EXT    = 2'd3
    } dlv_mode_e;

    typedef enum logic {
        FLT_ABSENT = 1'b0,
        FLT_RID    = 1'b1
    } fault_kind_e;

    typedef struct packed {
        logic               present;
        logic [RID_W-1:0]   rid;
        logic [VEC_W-1:0]   vector;
        logic [DEST_W-1:0]  dest;
        dlv_mode_e          mode;
    } remap_entry_t;

    typedef struct packed {
        logic        ok;
        fault_kind_e kind;
    } verdict_t;

    // Absence outranks a requester mismatch.
    function automatic verdict_t judge(input remap_entry_t e, input logic [RID_W-1:0] rid);
        verdict_t v;
        if (!e.present) begin
            v.ok   = 1'b0;
            v.kind = FLT_ABSENT;
        end else if (e.rid != rid) begin
            v.ok   = 1'b0;
            v.kind = FLT_RID;
        end else begin
            v.ok   = 1'b1;
            v.kind = FLT_ABSENT;
        end
        return v;
    endfunction

    localparam remap_entry_t EMPTY_ENTRY = '{present: 1'b0, rid: '0, vector: '0,
                                             dest: '0, mode: MODE_FIXED};

endpackage

// File: rtl/irq_remap_table.sv
module irq_remap_table
    import irq_remap_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ID_W-1:0]     wr_idx,
    input  remap_entry_t        wr_entry,
    input  logic [ID_W-1:0]     rd_idx,
    output remap_entry_t        rd_entry
);
    localparam int DEPTH = 1 << ID_W;

    remap_entry_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= EMPTY_ENTRY;
            end else if (wr_en && (wr_idx == ID_W'(g))) begin
                slot_q[g] <= wr_entry;
            end
        end
    end

    assign rd_entry = slot_q[rd_idx];

endmodule

// File: rtl/irq_remap_cache.sv
module irq_remap_cache
    import irq_remap_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int LINE_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ID_W-1:0]     look_id,
    output logic                look_hit,
    output remap_entry_t        look_entry,
    input  logic                fill_en,
    input  logic [ID_W-1:0]     fill_id,
    input  remap_entry_t        fill_entry,
    input  logic                inv_en,
    input  logic [ID_W-1:0]     inv_id
);
    localparam int LINES = 1 << LINE_W;
    localparam int TAG_W = ID_W - LINE_W;

    logic               vld_q [LINES];
    logic [TAG_W-1:0]   tag_q [LINES];
    remap_entry_t       dat_q [LINES];

    logic [LINE_W-1:0]  look_line, fill_line, inv_line;
    logic [TAG_W-1:0]   look_tag,  fill_tag,  inv_tag;

    assign look_line = look_id[LINE_W-1:0];
    assign look_tag  = look_id[ID_W-1:LINE_W];
    assign fill_line = fill_id[LINE_W-1:0];
    assign fill_tag  = fill_id[ID_W-1:LINE_W];
    assign inv_line  = inv_id[LINE_W-1:0];
    assign inv_tag   = inv_id[ID_W-1:LINE_W];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic fill_here, inv_here;
        assign fill_here = fill_en && (fill_line == LINE_W'(g));
        assign inv_here  = inv_en && (inv_line == LINE_W'(g)) && (tag_q[g] == inv_tag);

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[g] <= 1'b0;
                tag_q[g] <= '0;
                dat_q[g] <= EMPTY_ENTRY;
            end else if (fill_here) begin
                // A fill brings a fresh copy; the owner guarantees it is not stale.
                vld_q[g] <= 1'b1;
                tag_q[g] <= fill_tag;
                dat_q[g] <= fill_entry;
            end else if (inv_here) begin
                vld_q[g] <= 1'b0;
            end
        end
    end

    assign look_hit   = vld_q[look_line] && (tag_q[look_line] == look_tag);
    assign look_entry = dat_q[look_line];

endmodule

// File: rtl/irq_remap_seq.sv
module irq_remap_seq
    import irq_remap_pkg::*;
#(
    parameter int ID_W     = 8,
    parameter int MISS_LAT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                hit,
    input  remap_entry_t        hit_entry,
    input  logic [ID_W-1:0]     msg_id,
    input  logic [RID_W-1:0]    msg_rid,
    input  remap_entry_t        tbl_entry,
    output logic                busy,
    output logic                done,
    output logic [ID_W-1:0]     pend_id,
    output logic                irq_valid,
    output logic [VEC_W-1:0]    irq_vector,
    output logic [DEST_W-1:0]   irq_dest,
    output logic [1:0]          irq_mode,
    output logic                fault_valid,
    output logic                fault_kind,
    output logic [ID_W-1:0]     fault_msg_id,
    output logic [RID_W-1:0]    fault_rid
);
    localparam int CNT_W = (MISS_LAT > 1) ? $clog2(MISS_LAT) : 1;

    logic [CNT_W-1:0]   cnt_q;
    logic               busy_q;
    logic [ID_W-1:0]    pid_q;
    logic [RID_W-1:0]   prid_q;

    logic               take;
    remap_entry_t       sel_e;
    logic [ID_W-1:0]    sel_id;
    logic [RID_W-1:0]   sel_rid;
    verdict_t           vd;

    remap_entry_t       out_e_q;
    logic               irq_v_q, flt_v_q;
    fault_kind_e        kind_q;
    logic [ID_W-1:0]    oid_q;
    logic [RID_W-1:0]   orid_q;

    assign done    = busy_q && (cnt_q == '0);
    assign busy    = busy_q;
    assign pend_id = pid_q;

    always_comb begin
        take    = (accept && hit) || done;
        sel_e   = done ? tbl_entry : hit_entry;
        sel_id  = done ? pid_q     : msg_id;
        sel_rid = done ? prid_q    : msg_rid;
        vd      = judge(sel_e, sel_rid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            pid_q   <= '0;
            prid_q  <= '0;
            irq_v_q <= 1'b0;
            flt_v_q <= 1'b0;
            out_e_q <= EMPTY_ENTRY;
            kind_q  <= FLT_ABSENT;
            oid_q   <= '0;
            orid_q  <= '0;
        end else begin
            irq_v_q <= take &&  vd.ok;
            flt_v_q <= take && !vd.ok;
            if (take) begin
                out_e_q <= sel_e;
                kind_q  <= vd.kind;
                oid_q   <= sel_id;
                orid_q  <= sel_rid;
            end
            if (accept && !hit) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(MISS_LAT - 1);
                pid_q  <= msg_id;
                prid_q <= msg_rid;
            end else if (done) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign irq_valid    = irq_v_q;
    assign irq_vector   = out_e_q.vector;
    assign irq_dest     = out_e_q.dest;
    assign irq_mode     = out_e_q.mode;
    assign fault_valid  = flt_v_q;
    assign fault_kind   = kind_q;
    assign fault_msg_id = oid_q;
    assign fault_rid    = orid_q;

endmodule

// File: rtl/irq_remap_unit.sv
module irq_remap_unit
    import irq_remap_pkg::*;
#(
    parameter int ID_W     = 8,
    parameter int LINE_W   = 3,
    parameter int MISS_LAT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                msg_valid,
    output logic                msg_ready,
    input  logic [ID_W-1:0]     msg_id,
    input  logic [15:0]         msg_rid,
    input  logic                host_we,
    input  logic [ID_W-1:0]     host_idx,
    input  logic                host_present,
    input  logic [15:0]         host_rid,
    input  logic [7:0]          host_vector,
    input  logic [7:0]          host_dest,
    input  logic [1:0]          host_mode,
    output logic                irq_valid,
    output logic [7:0]          irq_vector,
    output logic [7:0]          irq_dest,
    output logic [1:0]          irq_mode,
    output logic                fault_valid,
    output logic                fault_kind,
    output logic [ID_W-1:0]     fault_msg_id,
    output logic [15:0]         fault_rid
);
    remap_entry_t   host_entry, tbl_entry, hit_entry;
    logic           raw_hit, lookup_hit, accept, busy, done, fill_en;
    logic [ID_W-1:0] pend_id;

    assign host_entry = '{present: host_present, rid: host_rid, vector: host_vector,
                          dest: host_dest, mode: dlv_mode_e'(host_mode)};

    assign msg_ready  = !busy;
    assign accept     = msg_valid && msg_ready;
    // A write to the same handle in the acceptance cycle makes the cached copy stale.
    assign lookup_hit = raw_hit && !(host_we && (host_idx == msg_id));
    assign fill_en    = done && !(host_we && (host_idx == pend_id));

    irq_remap_table #(.ID_W(ID_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_we),
        .wr_idx   (host_idx),
        .wr_entry (host_entry),
        .rd_idx   (pend_id),
        .rd_entry (tbl_entry)
    );

    irq_remap_cache #(.ID_W(ID_W), .LINE_W(LINE_W)) u_cache (
        .clk        (clk),
        .rst        (rst),
        .look_id    (msg_id),
        .look_hit   (raw_hit),
        .look_entry (hit_entry),
        .fill_en    (fill_en),
        .fill_id    (pend_id),
        .fill_entry (tbl_entry),
        .inv_en     (host_we),
        .inv_id     (host_idx)
    );

    irq_remap_seq #(.ID_W(ID_W), .MISS_LAT(MISS_LAT)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .hit          (lookup_hit),
        .hit_entry    (hit_entry),
        .msg_id       (msg_id),
        .msg_rid      (msg_rid),
        .tbl_entry    (tbl_entry),
        .busy         (busy),
        .done         (done),
        .pend_id      (pend_id),
        .irq_valid    (irq_valid),
        .irq_vector   (irq_vector),
        .irq_dest     (irq_dest),
        .irq_mode     (irq_mode),
        .fault_valid  (fault_valid),
        .fault_kind   (fault_kind),
        .fault_msg_id (fault_msg_id),
        .fault_rid    (fault_rid)
    );

endmodule

// File: rtl/irq_remap_chk.sv
module irq_remap_chk #(
    parameter int ID_W     = 8,
    parameter int MISS_LAT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [ID_W-1:0]  msg_id,
    input logic             host_we,
    input logic [ID_W-1:0]  host_idx,
    input logic             hit,
    input logic             irq_valid,
    input logic             fault_valid
);
    logic       accept, out_v;
    logic [1:0] pend_q;
    logic       in_miss_q;
    logic [7:0] wcnt_q;

    assign accept = msg_valid && msg_ready;
    assign out_v  = irq_valid || fault_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            in_miss_q <= 1'b0;
            wcnt_q    <= '0;
        end else begin
            pend_q <= pend_q + {1'b0, accept} - {1'b0, out_v};
            if (accept && !hit) begin
                in_miss_q <= 1'b1;
                wcnt_q    <= '0;
            end else begin
                if (out_v) in_miss_q <= 1'b0;
                if (wcnt_q != 8'hFF) wcnt_q <= wcnt_q + 1'b1;
            end
        end
    end

    // R8
    assert_one_result_R8: assert property (@(posedge clk) disable iff (rst)
        !(irq_valid && fault_valid));
    assert_result_owed_R8: assert property (@(posedge clk) disable iff (rst)
        out_v |-> (pend_q != 2'd0));
    // R5
    assert_hit_next_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |=> out_v);
    // R6
    assert_miss_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit) |=> !msg_ready);
    assert_miss_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (out_v && in_miss_q) |-> (wcnt_q == 8'(MISS_LAT)));
    assert_stall_only_miss_R6: assert property (@(posedge clk) disable iff (rst)
        !msg_ready |-> in_miss_q);
    // R7
    assert_same_cycle_inval_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && host_we && (host_idx == msg_id)) |-> !hit);
    assert_next_cycle_inval_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && $past(host_we) && (msg_id == $past(host_idx))) |-> !hit);

endmodule

bind irq_remap_unit irq_remap_chk #(.ID_W(ID_W), .MISS_LAT(MISS_LAT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_id      (msg_id),
    .host_we     (host_we),
    .host_idx    (host_idx),
    .hit         (lookup_hit),
    .irq_valid   (irq_valid),
    .fault_valid (fault_valid)
);

// File: tb/irq_remap_unit_bench.sv
`timescale 1ns/1ps
module irq_remap_unit_bench;

    localparam int ID_W = 8, LINE_W = 3, MISS_LAT = 4;
    localparam int LINES = 1 << LINE_W;

    logic clk = 1'b0, rst = 1'b1;
    logic msg_valid = 1'b0;
    logic msg_ready;
    logic [ID_W-1:0] msg_id = '0;
    logic [15:0] msg_rid = '0;
    logic host_we = 1'b0;
    logic [ID_W-1:0] host_idx = '0;
    logic host_present = 1'b0;
    logic [15:0] host_rid = '0;
    logic [7:0] host_vector = '0, host_dest = '0;
    logic [1:0] host_mode = '0;
    logic irq_valid, fault_valid, fault_kind;
    logic [7:0] irq_vector, irq_dest;
    logic [1:0] irq_mode;
    logic [ID_W-1:0] fault_msg_id;
    logic [15:0] fault_rid;

    irq_remap_unit #(.ID_W(ID_W), .LINE_W(LINE_W), .MISS_LAT(MISS_LAT)) u_irq_remap_unit (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_id(msg_id), .msg_rid(msg_rid), .host_we(host_we), .host_idx(host_idx),
        .host_present(host_present), .host_rid(host_rid), .host_vector(host_vector),
        .host_dest(host_dest), .host_mode(host_mode), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_dest(irq_dest), .irq_mode(irq_mode),
        .fault_valid(fault_valid), .fault_kind(fault_kind),
        .fault_msg_id(fault_msg_id), .fault_rid(fault_rid)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic        present;
        logic [15:0] rid;
        logic [7:0]  vec;
        logic [7:0]  dest;
        logic [1:0]  mode;
    } ent_t;

    typedef struct {
        int          due;
        logic        is_fault;
        logic        kind;
        logic [7:0]  vec;
        logic [7:0]  dest;
        logic [1:0]  mode;
        logic [ID_W-1:0] id;
        logic [15:0] rid;
        string       req;
    } exp_t;

    ent_t tbl [1 << ID_W];
    logic cv [LINES];
    logic [ID_W-LINE_W-1:0] ct [LINES];
    exp_t q [$];

    int cyc = 0;
    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && cyc > q[0].due) begin
                exp_t m;
                m = q.pop_front();
                check(1'b0, m.req, "result missing at due cycle", cyc, m.due);
            end
            if (irq_valid || fault_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8", "unexpected result", {irq_valid, fault_valid}, 0);
                end else begin
                    exp_t e;
                    bit ok;
                    e = q.pop_front();
                    check(cyc == e.due, e.req, "result cycle", cyc, e.due);
                    check(fault_valid == e.is_fault && irq_valid == !e.is_fault, e.req,
                          "result type fault/irq", {fault_valid, irq_valid},
                          {e.is_fault, !e.is_fault});
                    if (e.is_fault)
                        ok = (fault_kind == e.kind) && (fault_msg_id == e.id) &&
                             (fault_rid == e.rid);
                    else
                        ok = (irq_vector == e.vec) && (irq_dest == e.dest) &&
                             (irq_mode == e.mode);
                    check(ok, e.req, e.is_fault ? "fault kind/id/rid" : "vector/dest/mode",
                          e.is_fault ? {fault_kind, fault_msg_id, fault_rid}
                                     : {irq_vector, irq_dest, irq_mode},
                          e.is_fault ? {e.kind, e.id, e.rid} : {e.vec, e.dest, e.mode});
                end
            end
        end
    end

    function automatic void model_write(input logic [ID_W-1:0] idx, input ent_t n);
        int ln;
        ln = int'(idx) % LINES;
        tbl[idx] = n;
        if (cv[ln] && ct[ln] == idx[ID_W-1:LINE_W]) cv[ln] = 1'b0;
    endfunction

    function automatic void model_accept(input logic [ID_W-1:0] id, input logic [15:0] rid,
                                         input int acc_edge, input string req);
        int ln;
        bit hit;
        exp_t e;
        ln  = int'(id) % LINES;
        hit = cv[ln] && (ct[ln] == id[ID_W-1:LINE_W]);
        e.due = hit ? acc_edge : acc_edge + MISS_LAT;
        e.id = id; e.rid = rid; e.req = req;
        e.vec = tbl[id].vec; e.dest = tbl[id].dest; e.mode = tbl[id].mode;
        if (!tbl[id].present) begin
            e.is_fault = 1'b1; e.kind = 1'b0;
        end else if (tbl[id].rid != rid) begin
            e.is_fault = 1'b1; e.kind = 1'b1;
        end else begin
            e.is_fault = 1'b0; e.kind = 1'b0;
        end
        if (!hit) begin
            cv[ln] = 1'b1;
            ct[ln] = id[ID_W-1:LINE_W];
        end
        q.push_back(e);
    endfunction

    task automatic drive_host(input logic [ID_W-1:0] idx, input ent_t n);
        host_we = 1'b1; host_idx = idx; host_present = n.present; host_rid = n.rid;
        host_vector = n.vec; host_dest = n.dest; host_mode = n.mode;
    endtask

    task automatic host_write(input logic [ID_W-1:0] idx, input ent_t n);
        @(negedge clk);
        while (!msg_ready) @(negedge clk);
        drive_host(idx, n);
        model_write(idx, n);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // Holds msg_valid while the unit stalls (R8).
    task automatic send(input logic [ID_W-1:0] id, input logic [15:0] rid, input string req);
        @(negedge clk);
        msg_valid = 1'b1; msg_id = id; msg_rid = rid;
        while (!msg_ready) @(negedge clk);
        model_accept(id, rid, cyc + 1, req);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic send_with_write(input logic [ID_W-1:0] id, input logic [15:0] rid,
                                   input ent_t n, input string req);
        @(negedge clk);
        while (!msg_ready) @(negedge clk);
        msg_valid = 1'b1; msg_id = id; msg_rid = rid;
        drive_host(id, n);
        model_write(id, n);
        model_accept(id, rid, cyc + 1, req);
        @(negedge clk);
        msg_valid = 1'b0; host_we = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < (1 << ID_W); i++) tbl[i] = '{1'b0, 16'h0, 8'h0, 8'h0, 2'd0};
        for (int i = 0; i < LINES; i++) begin cv[i] = 1'b0; ct[i] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(msg_ready == 1'b1, "R1", "ready after reset", msg_ready, 1);
        check(!irq_valid && !fault_valid, "R1", "no result after reset",
              {irq_valid, fault_valid}, 0);

        send(8'd5, 16'h1234, "R1");                        // empty table: absent fault (R3)
        drain();
        host_write(8'd5, '{1'b1, 16'h1234, 8'h41, 8'h07, 2'd1});
        send(8'd5, 16'h1234, "R7");                        // invalidated, miss, new contents
        send(8'd5, 16'h1234, "R8");                        // hit held behind miss
        send(8'd5, 16'h9999, "R4");                        // hit, requester mismatch
        drain();

        host_write(8'd13, '{1'b1, 16'h0A0B, 8'h20, 8'h03, 2'd2});
        send(8'd13, 16'h0A0B, "R6");                       // same line as 5: evicts
        send(8'd5,  16'h1234, "R6");                       // miss again after eviction
        send(8'd5,  16'h1234, "R5");                       // hit
        drain();

        host_write(8'd20, '{1'b0, 16'h5555, 8'h11, 8'h22, 2'd3});
        send(8'd20, 16'h7777, "R9");                       // absent outranks mismatch
        send(8'd20, 16'h5555, "R3");                       // absent, hit on cached absent
        drain();

        send_with_write(8'd5, 16'h1234, '{1'b1, 16'h1234, 8'h77, 8'h09, 2'd0}, "R7");
        send(8'd5, 16'h1234, "R7");
        drain();

        for (int k = 0; k < 8; k++) begin
            host_write(8'(32 + k), '{1'b1, 16'(16'h0100 + k), 8'(8'h80 + k),
                                     8'(k * 3), 2'(k)});
        end
        for (int k = 0; k < 8; k++) begin
            send(8'(32 + k), 16'(16'h0100 + k), "R2");
            send(8'(32 + k), 16'(16'h0100 + k), "R5");
        end
        drain();

        check(q.size() == 0, "R8", "all results delivered", q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule